// File: doc/BRIEF.md
# Non-Maskable Trap Sequencer

This block sits beside the instruction sequencer of a processor core and turns a trap request into a forced branch to a fixed handler address. A request can come from two places. The first is an external trap pin, which is asynchronous to the core clock. The second is a debug request, which is already synchronous. Traps cannot be masked and rank above every ordinary interrupt.

The trap does not cut an instruction short. The instruction in flight finishes first, including any wait states. The branch is raised at the next instruction boundary that is not stalled. At that boundary the block saves a return address, and the value depends on how many cycles the finishing instruction took. Once a trap is in service, further requests are dropped until the handler signals its return.

The externally visible acknowledge and vector pins behave differently for the two trap kinds. During a user trap they show a dedicated trap code. During a debug trap they stay frozen at the interrupt state that was present when the trap was taken.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, branch_o, trap_active_o, ack_o, vec_o, branch_addr_o and ret_addr_o are all zero.
- R2: A rising edge on trap_pin_i produces exactly one branch_o pulse, one cycle wide, with branch_addr_o = 0x0046. With instruction boundaries present every cycle, branch_o is high after the 4th rising clock edge that follows the pin going high.
- R3: A trap pin held high produces only one trap. No second trap follows after the handler returns.
- R4: A pending trap is taken only in a cycle where insn_end_i is 1 and wait_i is 0. The branch_o pulse appears after the clock edge that ends that cycle.
- R5: At the taken boundary, ret_addr_o captures one of two values. If insn_two_cyc_i is 1 it captures pc_i. If insn_two_cyc_i is 0 it captures pc_i + 1.
- R6: Trap-pin edges and debug requests that arrive while trap_active_o is 1 are discarded. They cause no branch, either during the handler or after it returns.
- R7: A trap_ret_i pulse while trap_active_o is 1 clears trap_active_o at the next edge. After that, new traps are accepted again.
- R8: While a user trap is active, ack_o is 1 and vec_o is 4'hF. The pins show this from the branch cycle up to and including the cycle of the clock edge that applies the return.
- R9: A one-cycle pulse on dbg_trap_i, sampled at a clock edge, produces a branch_o pulse after the next edge, with branch_addr_o = 0x0003. While the debug trap is active, ack_o and vec_o keep the values of irq_ack_i and irq_vec_i from the take cycle.
- R10: When a user trap and a debug trap are both pending, the user trap is taken. The debug request is discarded.
- R11: A trap is taken even while irq_ack_i is 1. A later trap overwrites ret_addr_o.
- R12: When no trap is active, ack_o and vec_o equal irq_ack_i and irq_vec_i delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_pin_i | input | 1 | Asynchronous user trap request pin |
| dbg_trap_i | input | 1 | Synchronous debug trap request pulse |
| insn_end_i | input | 1 | An instruction completes in this cycle |
| insn_two_cyc_i | input | 1 | The completing instruction is a two-cycle one |
| wait_i | input | 1 | Wait-state stall in this cycle |
| pc_i | input | 16 | Address of the instruction after the completing one |
| trap_ret_i | input | 1 | Trap handler return strobe |
| irq_ack_i | input | 1 | Interrupt acknowledge from the interrupt logic |
| irq_vec_i | input | 4 | Interrupt source code from the interrupt logic |
| branch_o | output | 1 | One-cycle branch request to the sequencer |
| branch_addr_o | output | 16 | Handler address for the branch |
| ret_addr_o | output | 16 | Saved return address |
| trap_active_o | output | 1 | A trap handler is in service |
| ack_o | output | 1 | Visible acknowledge pin |
| vec_o | output | 4 | Visible vector pin |

## Verification
The user trap is first driven with boundaries present every cycle, which fixes the exact pin-to-branch latency. It is then driven with boundaries withheld or stalled, which separates "pending" from "taken". Two-cycle and one-cycle boundaries with distinct pc_i values tell the two return-address rules apart. Requests during service, a held pin, and simultaneous user and debug requests check the lockout and the priority. Debug traps with changing irq inputs tell a frozen pin view from a following one.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
   typedef enum logic [1:0] {
      TK_NONE  = 2'd0,
      TK_USER  = 2'd1,
      TK_DEBUG = 2'd2
   } trap_kind_e;
endpackage

// File: rtl/trap_pin_sync.sv
module trap_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("trap_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              seen_q;

   if (STAGES == 2) begin : g_two
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[0], pin_i};
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= chain_q[LAST];
   end

   assign rise_o = chain_q[LAST] & ~seen_q;
endmodule

// File: rtl/trap_take_ctl.sv
module trap_take_ctl
   import trap_seq_pkg::*;
#(
   parameter int              PC_W      = 16,
   parameter logic [PC_W-1:0] USER_VEC  = 'h46,
   parameter logic [PC_W-1:0] DEBUG_VEC = 'h3,
   parameter int              RET_STEP  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            user_rise_i,
   input  logic            dbg_req_i,
   input  logic            insn_end_i,
   input  logic            insn_two_cyc_i,
   input  logic            wait_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic            trap_ret_i,
   output logic            take_o,
   output trap_kind_e      take_kind_o,
   output logic            active_o,
   output trap_kind_e      kind_o,
   output logic            branch_o,
   output logic [PC_W-1:0] branch_addr_o,
   output logic [PC_W-1:0] ret_addr_o
);
   localparam logic [PC_W-1:0] STEP = PC_W'(RET_STEP);

   logic            pend_user_q, pend_dbg_q;
   logic            boundary;
   logic [PC_W-1:0] ret_next;
   logic [PC_W-1:0] vec_next;

   assign boundary    = insn_end_i & ~wait_i;
   assign take_o      = (pend_user_q | pend_dbg_q) & boundary & ~active_o;
   assign take_kind_o = pend_user_q ? TK_USER : TK_DEBUG;
   assign vec_next    = pend_user_q ? USER_VEC : DEBUG_VEC;
   assign ret_next    = insn_two_cyc_i ? pc_i : pc_i + STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_user_q <= 1'b0;
         pend_dbg_q  <= 1'b0;
      end else if (take_o) begin
         pend_user_q <= 1'b0;
         pend_dbg_q  <= 1'b0;
      end else if (!active_o) begin
         if (user_rise_i) pend_user_q <= 1'b1;
         if (dbg_req_i)   pend_dbg_q  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         kind_o   <= TK_NONE;
      end else if (take_o) begin
         active_o <= 1'b1;
         kind_o   <= take_kind_o;
      end else if (trap_ret_i && active_o) begin
         active_o <= 1'b0;
         kind_o   <= TK_NONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         branch_o      <= 1'b0;
         branch_addr_o <= '0;
         ret_addr_o    <= '0;
      end else begin
         branch_o <= take_o;
         if (take_o) begin
            branch_addr_o <= vec_next;
            ret_addr_o    <= ret_next;
         end
      end
   end
endmodule

// File: rtl/trap_pin_view.sv
module trap_pin_view
   import trap_seq_pkg::*;
#(
   parameter int               VEC_W     = 4,
   parameter logic [VEC_W-1:0] TRAP_CODE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  trap_kind_e       take_kind_i,
   input  logic             active_i,
   input  trap_kind_e       kind_i,
   input  logic             irq_ack_i,
   input  logic [VEC_W-1:0] irq_vec_i,
   output logic             ack_o,
   output logic [VEC_W-1:0] vec_o
);
   trap_kind_e eff_kind;
   logic       busy;
   logic       show_code;
   logic       freeze;

   assign busy      = take_i | active_i;
   assign eff_kind  = take_i ? take_kind_i : kind_i;
   assign show_code = busy && (eff_kind == TK_USER);
   assign freeze    = active_i && !take_i && (kind_i == TK_DEBUG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_o <= 1'b0;
         vec_o <= '0;
      end else if (show_code) begin
         ack_o <= 1'b1;
         vec_o <= TRAP_CODE;
      end else if (!freeze) begin
         ack_o <= irq_ack_i;
         vec_o <= irq_vec_i;
      end
   end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
   import trap_seq_pkg::*;
#(
   parameter int                 PC_W        = 16,
   parameter int                 VEC_W       = 4,
   parameter int                 SYNC_STAGES = 2,
   parameter int                 RET_STEP    = 1,
   parameter logic [PC_W-1:0]    USER_VEC    = 'h46,
   parameter logic [PC_W-1:0]    DEBUG_VEC   = 'h3,
   parameter logic [VEC_W-1:0]   TRAP_CODE   = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_pin_i,
   input  logic             dbg_trap_i,
   input  logic             insn_end_i,
   input  logic             insn_two_cyc_i,
   input  logic             wait_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic             trap_ret_i,
   input  logic             irq_ack_i,
   input  logic [VEC_W-1:0] irq_vec_i,
   output logic             branch_o,
   output logic [PC_W-1:0]  branch_addr_o,
   output logic [PC_W-1:0]  ret_addr_o,
   output logic             trap_active_o,
   output logic             ack_o,
   output logic [VEC_W-1:0] vec_o
);
   if (USER_VEC == DEBUG_VEC) begin : g_bad_vec
      $error("trap_sequencer: user and debug vectors must differ");
   end
   if (RET_STEP < 1) begin : g_bad_step
      $error("trap_sequencer: RET_STEP must be positive");
   end

   logic       user_rise;
   logic       take;
   trap_kind_e take_kind;
   trap_kind_e kind;

   trap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (trap_pin_i),
      .rise_o (user_rise)
   );

   trap_take_ctl #(
      .PC_W      (PC_W),
      .USER_VEC  (USER_VEC),
      .DEBUG_VEC (DEBUG_VEC),
      .RET_STEP  (RET_STEP)
   ) u_take (
      .clk            (clk),
      .rst_n          (rst_n),
      .user_rise_i    (user_rise),
      .dbg_req_i      (dbg_trap_i),
      .insn_end_i     (insn_end_i),
      .insn_two_cyc_i (insn_two_cyc_i),
      .wait_i         (wait_i),
      .pc_i           (pc_i),
      .trap_ret_i     (trap_ret_i),
      .take_o         (take),
      .take_kind_o    (take_kind),
      .active_o       (trap_active_o),
      .kind_o         (kind),
      .branch_o       (branch_o),
      .branch_addr_o  (branch_addr_o),
      .ret_addr_o     (ret_addr_o)
   );

   trap_pin_view #(
      .VEC_W     (VEC_W),
      .TRAP_CODE (TRAP_CODE)
   ) u_view (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_i      (take),
      .take_kind_i (take_kind),
      .active_i    (trap_active_o),
      .kind_i      (kind),
      .irq_ack_i   (irq_ack_i),
      .irq_vec_i   (irq_vec_i),
      .ack_o       (ack_o),
      .vec_o       (vec_o)
   );
endmodule

// File: rtl/trap_sequencer_sva.sv
module trap_sequencer_sva #(
   parameter int               PC_W      = 16,
   parameter int               VEC_W     = 4,
   parameter int               RET_STEP  = 1,
   parameter logic [PC_W-1:0]  USER_VEC  = 'h46,
   parameter logic [PC_W-1:0]  DEBUG_VEC = 'h3,
   parameter logic [VEC_W-1:0] TRAP_CODE = '1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             insn_end_i,
   input logic             insn_two_cyc_i,
   input logic             wait_i,
   input logic [PC_W-1:0]  pc_i,
   input logic             trap_ret_i,
   input logic             branch_o,
   input logic [PC_W-1:0]  branch_addr_o,
   input logic [PC_W-1:0]  ret_addr_o,
   input logic             trap_active_o,
   input logic             ack_o,
   input logic [VEC_W-1:0] vec_o
);
   localparam logic [PC_W-1:0] STEP = PC_W'(RET_STEP);

   assert_one_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      branch_o |=> !branch_o);

   assert_entry_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      branch_o |-> trap_active_o);

   assert_no_reentry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_active_o |=> !branch_o);

   assert_boundary_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_i || !insn_end_i) |=> !branch_o);

   assert_ret_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      branch_o |-> (ret_addr_o == ($past(insn_two_cyc_i) ? $past(pc_i)
                                                           : $past(pc_i) + STEP)));

   assert_return_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_ret_i && trap_active_o) |=> !trap_active_o);

   assert_user_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_active_o && branch_addr_o == USER_VEC) |-> (ack_o && vec_o == TRAP_CODE));

   assert_debug_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_active_o && !branch_o && branch_addr_o == DEBUG_VEC)
         |-> ($stable(ack_o) && $stable(vec_o)));
endmodule

bind trap_sequencer trap_sequencer_sva #(
   .PC_W      (PC_W),
   .VEC_W     (VEC_W),
   .RET_STEP  (RET_STEP),
   .USER_VEC  (USER_VEC),
   .DEBUG_VEC (DEBUG_VEC),
   .TRAP_CODE (TRAP_CODE)
) u_sva (
   .clk            (clk),
   .rst_n          (rst_n),
   .insn_end_i     (insn_end_i),
   .insn_two_cyc_i (insn_two_cyc_i),
   .wait_i         (wait_i),
   .pc_i           (pc_i),
   .trap_ret_i     (trap_ret_i),
   .branch_o       (branch_o),
   .branch_addr_o  (branch_addr_o),
   .ret_addr_o     (ret_addr_o),
   .trap_active_o  (trap_active_o),
   .ack_o          (ack_o),
   .vec_o          (vec_o)
);

// File: tb/tb_trap_sequencer.sv
`timescale 1ns/1ps
module tb_trap_sequencer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        trap_pin_i, dbg_trap_i, insn_end_i, insn_two_cyc_i, wait_i;
   logic [15:0] pc_i;
   logic        trap_ret_i, irq_ack_i;
   logic [3:0]  irq_vec_i;
   logic        branch_o, trap_active_o, ack_o;
   logic [15:0] branch_addr_o, ret_addr_o;
   logic [3:0]  vec_o;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   trap_sequencer dut (
      .clk(clk), .rst_n(rst_n), .trap_pin_i(trap_pin_i), .dbg_trap_i(dbg_trap_i),
      .insn_end_i(insn_end_i), .insn_two_cyc_i(insn_two_cyc_i), .wait_i(wait_i),
      .pc_i(pc_i), .trap_ret_i(trap_ret_i), .irq_ack_i(irq_ack_i), .irq_vec_i(irq_vec_i),
      .branch_o(branch_o), .branch_addr_o(branch_addr_o), .ret_addr_o(ret_addr_o),
      .trap_active_o(trap_active_o), .ack_o(ack_o), .vec_o(vec_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_return();
      trap_ret_i = 1'b1;
      step(1);
      trap_ret_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 branch", branch_o, 0);
      chk("R1 active", trap_active_o, 0);
      chk("R1 ack", ack_o, 0);
      chk("R1 vec", vec_o, 0);
      chk("R1 addr", branch_addr_o, 0);
      chk("R1 ret", ret_addr_o, 0);
   endtask

   task automatic t_user_basic();
      insn_end_i = 1; insn_two_cyc_i = 1; pc_i = 16'h0120;
      irq_ack_i = 0; irq_vec_i = 4'h2;
      trap_pin_i = 1;
      step(3);
      chk("R2 not before 4th edge", branch_o, 0);
      step(1);
      chk("R2 branch", branch_o, 1);
      chk("R2 vector", branch_addr_o, 16'h0046);
      chk("R5 two-cycle ret", ret_addr_o, 16'h0120);
      chk("R8 ack", ack_o, 1);
      chk("R8 vec", vec_o, 4'hF);
      step(1);
      chk("R2 single pulse", branch_o, 0);
      do_return();
      chk("R8 ack through return edge", ack_o, 1);
      chk("R7 cleared", trap_active_o, 0);
      step(6);
      chk("R3 held pin no retrigger", branch_o, 0);
      chk("R3 held pin still idle", trap_active_o, 0);
      chk("R12 follows after return", vec_o, 4'h2);
      trap_pin_i = 0;
      step(3);
   endtask

   task automatic t_one_cycle_ret();
      insn_two_cyc_i = 0; pc_i = 16'h0200;
      trap_pin_i = 1;
      step(4);
      chk("R5 one-cycle branch", branch_o, 1);
      chk("R5 one-cycle ret", ret_addr_o, 16'h0201);
      trap_pin_i = 0;
      do_return();
      step(3);
   endtask

   task automatic t_boundary_wait();
      insn_end_i = 0; wait_i = 0; insn_two_cyc_i = 1; pc_i = 16'h0333;
      trap_pin_i = 1;
      step(6);
      chk("R4 no boundary no branch", branch_o, 0);
      chk("R4 no boundary idle", trap_active_o, 0);
      insn_end_i = 1; wait_i = 1;
      step(3);
      chk("R4 stalled no branch", branch_o, 0);
      wait_i = 0;
      step(1);
      chk("R4 branch after stall", branch_o, 1);
      chk("R4 ret at taken boundary", ret_addr_o, 16'h0333);
      trap_pin_i = 0;
      do_return();
      step(3);
   endtask

   task automatic t_lockout();
      pc_i = 16'h0500;
      trap_pin_i = 1;
      step(4);
      chk("R6 first trap", branch_o, 1);
      trap_pin_i = 0;
      step(3);
      trap_pin_i = 1;
      step(5);
      dbg_trap_i = 1;
      step(1);
      dbg_trap_i = 0;
      step(3);
      chk("R6 no branch in service", branch_o, 0);
      do_return();
      step(6);
      chk("R6 dropped after return", branch_o, 0);
      chk("R6 idle after return", trap_active_o, 0);
      trap_pin_i = 0;
      step(3);
   endtask

   task automatic t_debug();
      irq_ack_i = 1; irq_vec_i = 4'h5;
      step(2);
      chk("R12 follow ack", ack_o, 1);
      chk("R12 follow vec", vec_o, 4'h5);
      dbg_trap_i = 1;
      step(1);
      dbg_trap_i = 0;
      chk("R9 not yet", branch_o, 0);
      step(1);
      chk("R9 branch", branch_o, 1);
      chk("R9 vector", branch_addr_o, 16'h0003);
      irq_ack_i = 0; irq_vec_i = 4'h9;
      step(3);
      chk("R9 ack frozen", ack_o, 1);
      chk("R9 vec frozen", vec_o, 4'h5);
      do_return();
      step(1);
      chk("R12 ack after debug", ack_o, 0);
      chk("R12 vec after debug", vec_o, 4'h9);
   endtask

   task automatic t_priority();
      insn_end_i = 0;
      trap_pin_i = 1;
      dbg_trap_i = 1;
      step(1);
      dbg_trap_i = 0;
      step(4);
      insn_end_i = 1;
      step(1);
      chk("R10 branch", branch_o, 1);
      chk("R10 user wins", branch_addr_o, 16'h0046);
      trap_pin_i = 0;
      do_return();
      step(5);
      chk("R10 debug discarded", trap_active_o, 0);
   endtask

   task automatic t_nonmask();
      irq_ack_i = 1; irq_vec_i = 4'h3; insn_two_cyc_i = 1; pc_i = 16'h0300;
      trap_pin_i = 1;
      step(4);
      chk("R11 taken during interrupt", branch_o, 1);
      chk("R11 first ret", ret_addr_o, 16'h0300);
      trap_pin_i = 0;
      do_return();
      step(3);
      pc_i = 16'h0400;
      trap_pin_i = 1;
      step(4);
      chk("R11 ret overwritten", ret_addr_o, 16'h0400);
      trap_pin_i = 0;
      do_return();
      step(2);
   endtask

   task automatic t_idle_return();
      do_return();
      chk("R7 return ignored when idle", trap_active_o, 0);
      irq_ack_i = 0; irq_vec_i = 4'hA;
      step(1);
      chk("R12 one-cycle follow", vec_o, 4'hA);
   endtask

   initial begin
      #500000;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 0; trap_pin_i = 0; dbg_trap_i = 0; insn_end_i = 1; insn_two_cyc_i = 1;
      wait_i = 0; pc_i = 0; trap_ret_i = 0; irq_ack_i = 0; irq_vec_i = 0;
      step(3);
      t_reset();
      rst_n = 1;
      step(2);
      t_user_basic();
      t_one_cycle_ret();
      t_boundary_wait();
      t_lockout();
      t_debug();
      t_priority();
      t_nonmask();
      t_idle_return();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule